// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block follows one warp through its control flow. All lanes of the warp share a single program counter and run in lock-step, but each lane can resolve a conditional branch its own way. For each issued instruction the block computes the warp's next program counter and the mask of lanes that stay enabled. When a branch splits the active lanes, the block runs the two groups one after the other and never together. The lanes that took the branch go first. The resume point and the lane mask of the not-taken group are saved on a hardware stack.

Each stack entry holds a resume PC, a lane mask and a reconvergence PC. A split pushes two entries. The first is a rejoin entry that carries the reconvergence PC and the whole pre-branch mask. The second carries the fall-through PC and the not-taken lanes. Whenever the PC the warp would move to equals the reconvergence PC of the top entry, that entry is popped and its PC and mask take over. A branch on which every active lane agrees leaves the stack alone. The fetch unit feeds `next_pc` back as `issue_pc` for the following instruction.

Top module: `simt_div_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads `next_pc` = RESET_PC and `active_mask` = all ones, and clears `stack_overflow`.
- R2: A non-branch issue with no matching reconvergence point sets `next_pc` = `issue_pc` + PC_STEP and leaves `active_mask` unchanged.
- R3: A branch where (`taken_mask` AND `active_mask`) equals `active_mask` sets `next_pc` = `target_pc`, keeps the mask, and pushes nothing.
- R4: A branch where (`taken_mask` AND `active_mask`) is zero sets `next_pc` = `fallthru_pc`, keeps the mask, and pushes nothing.
- R5: Any other branch is a split. It sets `next_pc` = `target_pc` and `active_mask` = `taken_mask` AND `active_mask`.
- R6: When the candidate next PC equals the top entry's reconvergence PC, the top entry is popped. The block then resumes at the split's `fallthru_pc` with the not-taken lanes (pre-branch mask AND NOT `taken_mask`). This also holds when the candidate comes from a uniform branch.
- R7: When the not-taken group reaches the reconvergence PC, the block resumes at that PC with the full pre-branch mask.
- R8: Splits nested inside a taken path unwind in last-in, first-out order. The inner groups rejoin before the outer not-taken group runs.
- R9: A split that finds fewer than two free stack slots sets `stack_overflow`, which then stays set until reset. Nothing is pushed, and the warp still moves to `target_pc` with the taken lanes.
- R10: With `issue_valid` low, `next_pc` and `active_mask` hold, whatever the other inputs carry.
- R11: `active_mask` is never all zero after reset.
- R12: Bits of `taken_mask` for lanes that are not active have no effect on how a branch is classified or on the resulting mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction of this warp issues this cycle |
| issue_pc | input | PC_W | PC of the issuing instruction |
| is_branch | input | 1 | The issuing instruction is a conditional branch |
| taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| target_pc | input | PC_W | Branch target |
| fallthru_pc | input | PC_W | PC after the branch when not taken |
| reconv_pc | input | PC_W | Point where both paths of the branch rejoin |
| next_pc | output | PC_W | PC the warp executes next |
| active_mask | output | LANES | Lanes enabled for the next instruction |
| stack_overflow | output | 1 | Sticky: a split was dropped for lack of stack space |

## Verification
Two functions can fall in the same cycle: a pop, and the PC update of a uniform branch. This happens when the branch's chosen target or fall-through address is itself the reconvergence PC of the current top entry. The bench provokes this inside a taken path with an all-taken branch and with an all-not-taken branch, each aimed at the rejoin address. Either way the pop must win, so the next cycle must show the saved fall-through PC and the complementary lane mask, not the branch address. Exhaustive sweeps of every taken mask at one and two nesting levels check the order in which the paths run and the masks at each rejoin.

// File: rtl/simt_div_pkg.sv
// Package: shared types for the warp divergence stack.
// Assumes: nothing beyond IEEE 1800-2017.
package simt_div_pkg;

    // How an issued instruction moves the warp
    typedef enum logic [1:0] {
        BR_NONE      = 2'd0,  // not a branch: sequential
        BR_ALL_TAKEN = 2'd1,  // every active lane takes the branch
        BR_ALL_FALL  = 2'd2,  // no active lane takes the branch
        BR_SPLIT     = 2'd3   // active lanes disagree
    } br_class_e;

endpackage

// File: rtl/lane_split_classifier.sv
// Module: lane_split_classifier
// Classifies one issued instruction against the warp's active lanes and
// produces the masked taken set. Purely combinational.
// Assumes: active_mask is never zero (held by the top module).
module lane_split_classifier
    import simt_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             is_branch,
    input  logic [LANES-1:0] active_mask,
    input  logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] eff_taken,
    output br_class_e        br_class
);

    // Mask out inactive lanes, then decide uniform or split
    always_comb begin
        eff_taken = taken_mask & active_mask;
        if (!is_branch)
            br_class = BR_NONE;
        else if (eff_taken == active_mask)
            br_class = BR_ALL_TAKEN;
        else if (eff_taken == '0)
            br_class = BR_ALL_FALL;
        else
            br_class = BR_SPLIT;
    end

endmodule

// File: rtl/next_pc_select.sv
// Module: next_pc_select
// Picks the candidate next PC from the instruction class, before any
// reconvergence pop is considered. Purely combinational.
// Assumes: a split always runs the taken group first.
module next_pc_select
    import simt_div_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 1
) (
    input  br_class_e        br_class,
    input  logic [PC_W-1:0]  issue_pc,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  fallthru_pc,
    output logic [PC_W-1:0]  cand_pc
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    // Sequential, target or fall-through address
    always_comb begin
        unique case (br_class)
            BR_NONE:      cand_pc = issue_pc + STEP_V;
            BR_ALL_FALL:  cand_pc = fallthru_pc;
            default:      cand_pc = target_pc;
        endcase
    end

endmodule

// File: rtl/recon_stack.sv
// Module: recon_stack
// LIFO of reconvergence entries. It pushes two entries at once (lo first,
// hi on top) or pops one entry. The top entry is read combinationally.
// Assumes: the caller pushes only when has_pair_room is high and never
// pops when empty; a push and a pop never occur in the same cycle.
module recon_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_pair,
    input  logic [W-1:0] lo_entry,
    input  logic [W-1:0] hi_entry,
    input  logic         pop,
    output logic [W-1:0] top_entry,
    output logic         empty,
    output logic         has_pair_room
);

    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] PAIR_LIMIT = SP_W'(DEPTH - 2);

    logic [SP_W-1:0] sp;
    logic [W-1:0]    slots [DEPTH];

    // Occupancy counter: +2 on a pair push, -1 on a pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (push_pair)
            sp <= sp + SP_W'(2);
        else if (pop)
            sp <= sp - SP_W'(1);
    end

    // Entry storage: write the two slots just above the current top
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_pair && sp == SP_W'(i))
                slots[i] <= lo_entry;
            else if (push_pair && (sp + SP_W'(1)) == SP_W'(i))
                slots[i] <= hi_entry;
        end
    end

    // Top-of-stack read mux
    always_comb begin
        top_entry = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sp == SP_W'(i + 1))
                top_entry = slots[i];
    end

    assign empty         = (sp == '0);
    assign has_pair_room = (sp <= PAIR_LIMIT);

endmodule

// File: rtl/simt_div_stack.sv
// Module: simt_div_stack (top)
// Tracks one warp's PC and active-lane mask through divergent branches.
// Splits run the taken group first and save the fall-through group and a
// rejoin entry on a stack. Reaching the top entry's reconvergence PC pops it.
// Assumes: next_pc is fed back as issue_pc; each nesting level uses a
// distinct reconvergence PC; DEPTH >= 2 and even.
module simt_div_stack
    import simt_div_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int PC_W     = 32,
    parameter int DEPTH    = 16,
    parameter int PC_STEP  = 1,
    parameter int RESET_PC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [PC_W-1:0]  issue_pc,
    input  logic             is_branch,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  fallthru_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             stack_overflow
);

    // Entry layout: {resume_pc, reconv_pc, lane_mask}
    localparam int ENTRY_W  = 2 * PC_W + LANES;
    localparam int RPC_LSB  = LANES;
    localparam int RES_LSB  = LANES + PC_W;

    logic [LANES-1:0]   eff_taken;
    br_class_e          br_class;
    logic [PC_W-1:0]    cand_pc;
    logic [ENTRY_W-1:0] lo_entry, hi_entry, top_entry;
    logic               stk_empty, has_pair_room;
    logic               split, push_pair, overflow_now, pop;
    logic [PC_W-1:0]    top_resume, top_rpc;
    logic [LANES-1:0]   top_mask;

    lane_split_classifier #(.LANES(LANES)) u_classify (
        .is_branch   (is_branch),
        .active_mask (active_mask),
        .taken_mask  (taken_mask),
        .eff_taken   (eff_taken),
        .br_class    (br_class)
    );

    next_pc_select #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pcsel (
        .br_class    (br_class),
        .issue_pc    (issue_pc),
        .target_pc   (target_pc),
        .fallthru_pc (fallthru_pc),
        .cand_pc     (cand_pc)
    );

    recon_stack #(.DEPTH(DEPTH), .W(ENTRY_W)) u_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_pair     (push_pair),
        .lo_entry      (lo_entry),
        .hi_entry      (hi_entry),
        .pop           (pop),
        .top_entry     (top_entry),
        .empty         (stk_empty),
        .has_pair_room (has_pair_room)
    );

    // Unpack the top entry fields
    assign top_resume = top_entry[RES_LSB +: PC_W];
    assign top_rpc    = top_entry[RPC_LSB +: PC_W];
    assign top_mask   = top_entry[LANES-1:0];

    // Entries pushed on a split: rejoin entry below, fall-through on top
    assign lo_entry = {reconv_pc, reconv_pc, active_mask};
    assign hi_entry = {fallthru_pc, reconv_pc, active_mask & ~taken_mask};

    // Control decisions for this cycle
    always_comb begin
        split        = issue_valid && (br_class == BR_SPLIT);
        push_pair    = split && has_pair_room;
        overflow_now = split && !has_pair_room;
        pop          = issue_valid && !split && !stk_empty && (cand_pc == top_rpc);
    end

    // Warp PC, lane mask and sticky overflow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc        <= PC_W'(RESET_PC);
            active_mask    <= '1;
            stack_overflow <= 1'b0;
        end else begin
            if (overflow_now)
                stack_overflow <= 1'b1;
            if (pop) begin
                next_pc     <= top_resume;
                active_mask <= top_mask;
            end else if (issue_valid) begin
                next_pc <= cand_pc;
                if (split)
                    active_mask <= eff_taken;
            end
        end
    end

endmodule

// File: rtl/simt_div_stack_chk.sv
// Module: simt_div_stack_chk
// Port-level properties of simt_div_stack, attached by bind below.
// Assumes: reset is synchronous and active low.
module simt_div_stack_chk #(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic             is_branch,
    input logic [LANES-1:0] taken_mask,
    input logic [PC_W-1:0]  target_pc,
    input logic [PC_W-1:0]  next_pc,
    input logic [LANES-1:0] active_mask,
    input logic             stack_overflow
);

    // R11
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ($stable(next_pc) && $stable(active_mask)));

    // R5
    split_taken_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && is_branch && ((taken_mask & active_mask) != '0)
         && ((taken_mask & active_mask) != active_mask))
        |=> (next_pc == $past(target_pc)
             && active_mask == $past(taken_mask & active_mask)));

endmodule

bind simt_div_stack simt_div_stack_chk #(.LANES(LANES), .PC_W(PC_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .is_branch      (is_branch),
    .taken_mask     (taken_mask),
    .target_pc      (target_pc),
    .next_pc        (next_pc),
    .active_mask    (active_mask),
    .stack_overflow (stack_overflow)
);

// File: tb/test_simt_div_stack.sv
// Bench: sweeps of every taken mask on a 4-lane, 8-bit PC, depth-4 build.
module test_simt_div_stack;

    localparam int LN = 4;
    localparam int PW = 8;
    localparam int DP = 4;
    localparam logic [LN-1:0] FULL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [PW-1:0] issue_pc = '0;
    logic          is_branch = 1'b0;
    logic [LN-1:0] taken_mask = '0;
    logic [PW-1:0] target_pc = '0, fallthru_pc = '0, reconv_pc = '0;
    logic [PW-1:0] next_pc;
    logic [LN-1:0] active_mask;
    logic          stack_overflow;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    simt_div_stack #(.LANES(LN), .PC_W(PW), .DEPTH(DP), .PC_STEP(1), .RESET_PC(8))
    i_simt_div_stack (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_pc(issue_pc),
        .is_branch(is_branch), .taken_mask(taken_mask), .target_pc(target_pc),
        .fallthru_pc(fallthru_pc), .reconv_pc(reconv_pc), .next_pc(next_pc),
        .active_mask(active_mask), .stack_overflow(stack_overflow)
    );

    task automatic chk(input string req, input logic [PW-1:0] epc, input logic [LN-1:0] em);
        tests++;
        if (next_pc !== epc || active_mask !== em) begin
            fails++;
            $display("FAIL %s: pc=%h mask=%b expected pc=%h mask=%b",
                     req, next_pc, active_mask, epc, em);
        end
    endtask

    task automatic chk_err(input string req, input logic e);
        tests++;
        if (stack_overflow !== e) begin
            fails++;
            $display("FAIL %s: overflow=%b expected %b", req, stack_overflow, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        issue_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one instruction at the current PC; returns at the next negedge
    task automatic issue(input logic br, input logic [LN-1:0] tk,
                         input logic [PW-1:0] tg, input logic [PW-1:0] ft,
                         input logic [PW-1:0] rc);
        issue_valid = 1'b1;
        issue_pc    = next_pc;
        is_branch   = br;
        taken_mask  = tk;
        target_pc   = tg;
        fallthru_pc = ft;
        reconv_pc   = rc;
        @(negedge clk);
        issue_valid = 1'b0;
        is_branch   = 1'b0;
    endtask

    task automatic step();
        issue(1'b0, '0, '0, '0, '0);
    endtask

    task automatic step_until(input logic [PW-1:0] pc);
        for (int k = 0; k < 40 && next_pc != pc; k++) begin
            step();
            tests++;
            if (active_mask == '0) begin
                fails++;
                $display("FAIL R11: mask=%b expected nonzero", active_mask);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", 8'h08, FULL);
        chk_err("R1", 1'b0);

        // R10: inputs toggle but no issue
        is_branch = 1'b1; taken_mask = 4'b0101; target_pc = 8'h77;
        fallthru_pc = 8'h66; issue_pc = 8'h55;
        repeat (3) @(negedge clk);
        chk("R10", 8'h08, FULL);
        is_branch = 1'b0;

        // R2 sequential issue
        step();
        chk("R2", 8'h09, FULL);

        // Level-0 sweep of every taken mask
        for (int t = 0; t < 16; t++) begin
            logic [LN-1:0] tm;
            tm = LN'(t);
            do_reset();
            issue(1'b1, tm, 8'h10, 8'h09, 8'h14);
            if (tm == FULL) begin
                chk("R3", 8'h10, FULL);
                step_until(8'h14);
                chk("R3", 8'h14, FULL);
            end else if (tm == '0) begin
                chk("R4", 8'h09, FULL);
                step_until(8'h14);
                chk("R4", 8'h14, FULL);
            end else begin
                chk("R5", 8'h10, tm);
                step(); step(); step();
                chk("R5", 8'h13, tm);
                step();
                chk("R6", 8'h09, FULL & ~tm);
                for (int k = 0; k < 10; k++) step();
                chk("R6", 8'h13, FULL & ~tm);
                step();
                chk("R7", 8'h14, FULL);
            end
            chk_err("R9", 1'b0);
        end

        // Two-level sweep: inner branch inside the outer taken path
        for (int a = 1; a < 15; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [LN-1:0] t1, t2, e;
                t1 = LN'(a);
                t2 = LN'(b);
                e  = t1 & t2;
                do_reset();
                issue(1'b1, t1, 8'h10, 8'h09, 8'h14);
                issue(1'b1, t2, 8'h12, 8'h11, 8'h13);
                if (e == t1) begin
                    chk("R12", 8'h12, t1);
                end else if (e == '0) begin
                    chk("R12", 8'h11, t1);
                end else begin
                    chk("R12", 8'h12, e);
                    step();
                    chk("R8", 8'h11, t1 & ~e);
                    step(); step();
                    chk("R8", 8'h13, t1);
                end
                step_until(8'h09);
                chk("R8", 8'h09, FULL & ~t1);
                step_until(8'h14);
                chk("R8", 8'h14, FULL);
            end
        end

        // R6: uniform taken branch lands on the rejoin PC, pop wins
        do_reset();
        issue(1'b1, 4'b0011, 8'h10, 8'h09, 8'h14);
        issue(1'b1, 4'b1111, 8'h14, 8'h11, 8'h20);
        chk("R6", 8'h09, 4'b1100);
        // R6: uniform not-taken branch whose fall-through is the rejoin PC
        do_reset();
        issue(1'b1, 4'b0110, 8'h10, 8'h09, 8'h14);
        issue(1'b1, 4'b1001, 8'h30, 8'h14, 8'h20);
        chk("R6", 8'h09, 4'b1001);

        // R9 overflow on the third nested split
        do_reset();
        issue(1'b1, 4'b0111, 8'h20, 8'h09, 8'h14);
        issue(1'b1, 4'b0011, 8'h30, 8'h21, 8'h40);
        chk("R5", 8'h30, 4'b0011);
        chk_err("R9", 1'b0);
        issue(1'b1, 4'b0001, 8'h60, 8'h31, 8'h61);
        chk("R9", 8'h60, 4'b0001);
        chk_err("R9", 1'b1);
        step();
        chk("R9", 8'h61, 4'b0001);
        step(); step();
        chk_err("R9", 1'b1);
        do_reset();
        chk_err("R1", 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule